// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches a running calendar (BCD minute, BCD hour, BCD day of month and a binary weekday) and raises a sticky alarm flag when the time equals a programmed alarm. Comparison happens once per minute, on a single-cycle tick that the timekeeping logic supplies at every minute rollover. Each of the four alarm fields has its own disable bit, so any subset of fields can be treated as "don't care". With every field disabled, the alarm fires on every minute.

Software programs the unit through a plain write port: four alarm field registers and one control register. The control register holds the interrupt enable, the flag (cleared by writing 0) and the output style select. In level style the active-low interrupt follows the flag while the enable is set. In pulse style each match drives the interrupt low for a fixed number of clock cycles.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, alarm_flag is 0 and irq_n is 1. All four alarm fields have their disable bit set, and the control register is 0 (interrupt disabled, level style).
- R2: Write addresses are 0 = minute field, 1 = hour field, 2 = day field, 3 = weekday field and 4 = control. In the control register, bit 0 is the interrupt enable, bit 1 is the flag and bit 2 selects pulse style (1) or level style (0).
- R3: A field takes part in the match only when its bit 7 is 0. It compares BCD minute in bits 6:0, BCD hour in bits 5:0, BCD day in bits 5:0 and binary weekday in bits 2:0. The alarm matches when every enabled field equals the current time.
- R4: Matching is evaluated only in a cycle where min_tick is 1. An equal time without a tick never sets the flag.
- R5: When all four fields are disabled, every minute tick is a match.
- R6: A match sets alarm_flag, visible in the cycle after the tick. The flag stays set until software clears it.
- R7: Writing control with bit 1 = 0 clears the flag. Writing bit 1 = 1 leaves the flag unchanged and never sets it.
- R8: If a match and a clearing control write occur in the same cycle, the flag stays set.
- R9: irq_n is 0 only while the interrupt enable is 1 and alarm_flag is 1.
- R10: In level style, irq_n is 0 in every cycle in which the enable and the flag are both 1.
- R11: In pulse style, a match with the enable set drives irq_n low for exactly PULSE_CYCLES cycles starting the cycle after the tick. A match with the enable clear gives no pulse. Clearing the flag ends the pulse at once.
- R12: Writes to addresses 5 to 7 change neither the alarm fields nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| min_tick | input | 1 | One-cycle strobe at each minute rollover |
| now_min | input | 7 | Current minute, BCD |
| now_hour | input | 6 | Current hour, BCD |
| now_mday | input | 6 | Current day of month, BCD |
| now_wday | input | 3 | Current weekday, 0 to 6 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong disable bit or comparison mask shows up as alarm_flag disagreeing with the expected match one cycle after the tick. The sweep over all disable masks and all mismatch patterns exposes any single field defect at the first affected tick. A faulty flag update shows in the cycle after the write or tick concerned: a lost set/clear priority, or a flag set by writing 1. A wrong pulse counter changes the count of low irq_n cycles, visible within PULSE_CYCLES + 1 cycles of the match.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
   localparam int NUM_FIELDS = 4;
   localparam int REG_AW     = 3;
   localparam logic [REG_AW-1:0] CTRL_ADDR = 3'd4;
   localparam int CTRL_IE_BIT    = 0;
   localparam int CTRL_FLAG_BIT  = 1;
   localparam int CTRL_PULSE_BIT = 2;
   localparam int FIELD_OFF_BIT  = 7;
   localparam logic [7:0] FIELD_RESET = 8'h80;

   // compared width of each alarm field: minute, hour, day, weekday
   function automatic int field_width(input int idx);
      case (idx)
         0:       return 7;
         1:       return 6;
         2:       return 6;
         default: return 3;
      endcase
   endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
   parameter int W = 7
) (
   input  logic [7:0] alarm_val,
   input  logic [7:0] now_val,
   output logic       hit
);
   localparam logic [7:0] MASK = 8'((1 << W) - 1);

   if (W < 1 || W > 7) begin : g_bad_w
      $error("alarm_field_cmp: W must be 1..7");
   end

   always_comb begin
      hit = alarm_val[alarm_pkg::FIELD_OFF_BIT] |
            ((alarm_val & MASK) == (now_val & MASK));
   end
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
   import alarm_pkg::*;
(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [REG_AW-1:0]           wr_addr,
   input  logic [7:0]                  wr_data,
   input  logic                        match_evt,
   output logic [NUM_FIELDS-1:0][7:0]  fields,
   output logic                        irq_en,
   output logic                        pulse_mode,
   output logic                        flag
);
   logic ctrl_wr;
   logic flag_clr;

   assign ctrl_wr  = wr_en && (wr_addr == CTRL_ADDR);
   assign flag_clr = ctrl_wr && !wr_data[CTRL_FLAG_BIT];

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      always_ff @(posedge clk) begin
         if (!rst_n)
            fields[i] <= FIELD_RESET;
         else if (wr_en && (wr_addr == REG_AW'(i)))
            fields[i] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_en     <= 1'b0;
         pulse_mode <= 1'b0;
         flag       <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            irq_en     <= wr_data[CTRL_IE_BIT];
            pulse_mode <= wr_data[CTRL_PULSE_BIT];
         end
         flag <= match_evt | (flag & ~flag_clr);
      end
   end

   // R8
   match_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> flag);
   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);
   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !match_evt) |=> !flag);
endmodule

// File: rtl/alarm_irq_gen.sv
module alarm_irq_gen #(
   parameter int PULSE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic match_evt,
   input  logic flag,
   input  logic irq_en,
   input  logic pulse_mode,
   output logic irq_n
);
   localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PULSE_CYCLES);

   if (PULSE_CYCLES < 1) begin : g_bad_pulse
      $error("alarm_irq_gen: PULSE_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             fire;
   logic             active;

   assign fire = match_evt && irq_en && pulse_mode;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (fire)
         cnt <= CNT_MAX;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   always_comb begin
      if (pulse_mode)
         active = (cnt != '0) && flag && irq_en;
      else
         active = flag && irq_en;
      irq_n = ~active;
   end

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (flag && irq_en));
   // R11
   pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX);
   // R11
   pulse_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt == CNT_MAX));
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
   import alarm_pkg::*;
#(
   parameter int PULSE_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              min_tick,
   input  logic [6:0]        now_min,
   input  logic [5:0]        now_hour,
   input  logic [5:0]        now_mday,
   input  logic [2:0]        now_wday,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic              alarm_flag,
   output logic              irq_n
);
   logic [NUM_FIELDS-1:0][7:0] fields;
   logic [NUM_FIELDS-1:0][7:0] now_vec;
   logic [NUM_FIELDS-1:0]      hits;
   logic                       irq_en;
   logic                       pulse_mode;
   logic                       match_evt;

   assign now_vec[0] = {1'b0, now_min};
   assign now_vec[1] = {2'b0, now_hour};
   assign now_vec[2] = {2'b0, now_mday};
   assign now_vec[3] = {5'b0, now_wday};

   alarm_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .match_evt  (match_evt),
      .fields     (fields),
      .irq_en     (irq_en),
      .pulse_mode (pulse_mode),
      .flag       (alarm_flag)
   );

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
      alarm_field_cmp #(.W(field_width(i))) u_cmp (
         .alarm_val (fields[i]),
         .now_val   (now_vec[i]),
         .hit       (hits[i])
      );
   end

   assign match_evt = min_tick && (&hits);

   alarm_irq_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .match_evt  (match_evt),
      .flag       (alarm_flag),
      .irq_en     (irq_en),
      .pulse_mode (pulse_mode),
      .irq_n      (irq_n)
   );

   // R4
   tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(min_tick));
endmodule

// File: tb/sim_alarm_match_unit.sv
module sim_alarm_match_unit;
   localparam int CLK_PERIOD = 10;
   localparam int P = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       min_tick = 1'b0;
   logic [6:0] now_min = '0;
   logic [5:0] now_hour = '0;
   logic [5:0] now_mday = '0;
   logic [2:0] now_wday = '0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       alarm_flag;
   logic       irq_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alarm_match_unit #(.PULSE_CYCLES(P)) u0 (
      .clk(clk), .rst_n(rst_n), .min_tick(min_tick),
      .now_min(now_min), .now_hour(now_hour), .now_mday(now_mday),
      .now_wday(now_wday), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .alarm_flag(alarm_flag), .irq_n(irq_n)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      min_tick = 1'b1;
      @(negedge clk);
      min_tick = 1'b0;
   endtask

   task automatic set_now(input logic [6:0] m, input logic [5:0] h,
                          input logic [5:0] d, input logic [2:0] w);
      now_min = m; now_hour = h; now_mday = d; now_wday = w;
   endtask

   // alarm target: 45 min, 13 h, day 27, weekday 5
   task automatic program_alarm(input int off_mask);
      wr(3'd0, {off_mask[0], 7'h45});
      wr(3'd1, {off_mask[1], 7'h13});
      wr(3'd2, {off_mask[2], 7'h27});
      wr(3'd3, {off_mask[3], 7'h05});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 flag", alarm_flag, 0);
      check("R1 irq_n", irq_n, 1);

      // R4: no tick, no set (fields disabled after reset)
      set_now(7'h12, 6'h08, 6'h03, 3'd1);
      repeat (4) @(negedge clk);
      check("R4 no tick", alarm_flag, 0);

      // R5 + R1: reset fields all disabled -> any tick matches; irq off
      tick();
      check("R5 all off match", alarm_flag, 1);
      check("R1 irq disabled", irq_n, 1);

      // R7: writing 1 keeps flag set
      wr(3'd4, 8'h02);
      check("R7 write one keeps", alarm_flag, 1);
      wr(3'd4, 8'h00);
      check("R7 write zero clears", alarm_flag, 0);
      wr(3'd4, 8'h02);
      check("R7 write one no set", alarm_flag, 0);

      // R2/R3/R10 sweep: every disable mask x every mismatch pattern
      for (int m = 0; m < 16; m++) begin
         program_alarm(m);
         for (int p = 0; p < 16; p++) begin
            wr(3'd4, 8'h01);
            set_now(p[0] ? 7'h46 : 7'h45, p[1] ? 6'h14 : 6'h13,
                    p[2] ? 6'h28 : 6'h27, p[3] ? 3'd6 : 3'd5);
            tick();
            check($sformatf("R3 mask %0d pat %0d flag", m, p), alarm_flag,
                  ((p & ~m) == 0) ? 1 : 0);
            check($sformatf("R10 mask %0d pat %0d irq", m, p), irq_n,
                  ((p & ~m) == 0) ? 0 : 1);
         end
      end

      // R8: match and clear in the same cycle
      program_alarm(0);
      set_now(7'h45, 6'h13, 6'h27, 3'd5);
      wr(3'd4, 8'h00);
      @(negedge clk);
      min_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h00;
      @(negedge clk);
      min_tick = 1'b0; wr_en = 1'b0;
      check("R8 match wins", alarm_flag, 1);

      // R12: writes to 5..7 are ignored
      wr(3'd5, 8'h00);
      wr(3'd6, 8'h00);
      wr(3'd7, 8'h00);
      check("R12 ctrl untouched flag", alarm_flag, 1);
      wr(3'd4, 8'h00);
      set_now(7'h00, 6'h00, 6'h00, 3'd0);
      tick();
      check("R12 fields untouched", alarm_flag, 0);

      // R11 pulse style
      set_now(7'h45, 6'h13, 6'h27, 3'd5);
      wr(3'd4, 8'h05);
      tick();
      for (int k = 0; k < P; k++) begin
         check($sformatf("R11 pulse low cycle %0d", k), irq_n, 0);
         @(negedge clk);
      end
      check("R11 pulse end", irq_n, 1);
      check("R11 flag stays", alarm_flag, 1);
      // R9: enable clear -> no pulse
      wr(3'd4, 8'h04);
      tick();
      check("R9 no pulse when disabled", irq_n, 1);
      check("R6 flag set", alarm_flag, 1);
      // R11: clear ends pulse early
      wr(3'd4, 8'h05);
      tick();
      check("R11 pulse start", irq_n, 0);
      wr(3'd4, 8'h05);
      check("R11 clear ends pulse", irq_n, 1);
      // R4 with pulse style: mismatch tick no pulse
      set_now(7'h44, 6'h13, 6'h27, 3'd5);
      tick();
      check("R4 mismatch no pulse", irq_n, 1);
      check("R4 mismatch no flag", alarm_flag, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule